// File: doc/BRIEF.md
# I2C Byte Master with Event Status Codes

This block is the transmit-only master side of a two-wire serial controller. Software reaches it through four byte-wide registers: control, status, data and a stored own-address byte. Software requests a start and the controller sends it. After that, each bus event ends with three actions. The controller loads an 8-bit status code, raises a service flag, and holds the clock line low. The bus stays frozen until software clears the flag, so a transfer moves forward one event at a time. Both bus lines are open-drain. The outputs `scl_o` and `sda_o` read 1 for a released line and 0 for a line pulled low. `sda_in` carries the level seen on the data wire.

The sequencer is one state machine. It has these states:
- `ST_IDLE`: both lines released.
- `ST_S_SETUP`: both lines high.
- `ST_S_FALL`: data low while the clock is high, which is the start edge.
- `ST_S_LOW`: clock pulled low after the start.
- `ST_R_REL`: data released while the clock is low.
- `ST_R_RISE`: clock raised before a repeated start.
- `ST_HOLD`: clock held low while the flag is serviced.
- `ST_BIT`: shifts one data bit.
- `ST_ACK`: the acknowledge slot.
- `ST_P_LOW`, `ST_P_RISE`, `ST_P_REL`: the stop sequence.
- `ST_LOST`: after arbitration loss, both lines released.

The transitions are:
- IDLE→S_SETUP when enable and start are set and the flag is clear. IDLE stays in IDLE and drops a pending stop.
- S_SETUP→S_FALL→S_LOW, then S_LOW→HOLD, which posts the start or repeated-start code.
- HOLD, once the flag is clear, goes to P_LOW if stop is set. Otherwise it goes to R_REL if start is set. Otherwise it loads the data register and goes to BIT.
- R_REL→R_RISE→S_FALL.
- BIT→BIT from one bit to the next. BIT→ACK after the last bit. BIT→LOST on arbitration loss.
- ACK→HOLD, which posts an acknowledge or no-acknowledge code.
- P_LOW→P_RISE→P_REL→IDLE, which clears the stop bit.
- LOST→IDLE once the flag is clear.
- Clearing enable forces IDLE from any state.

Every timed step lasts one quarter of the clock period. A prescaler with parameter `QUARTER` sets that quarter.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, status reads 0xF8, control reads 0x00, `irq` is 0, and `scl_o` and `sda_o` are both 1 (released).
- R2: Register select values are 0 for control, 1 for status (read only), 2 for data and 3 for own-address. Control bits are: enable at bit 6, start at bit 5, stop at bit 4, flag at bit 3 and acknowledge-enable at bit 2. Control bits 7, 1 and 0 read as 0. The data and own-address registers read back what was written.
- R3: With enable and start set and the flag clear in idle, SDA falls while SCL is high and then SCL falls. Status then reads 0x08 and the flag sets.
- R4: Writing 0 to control bit 3 clears the flag. Writing 1 to it leaves the flag unchanged, so software cannot set the flag.
- R5: While the flag is set after a start or a byte, SCL stays low and the bus does not move.
- R6: The first byte after a start or repeated start is the data register, sent MSB first. ACK (SDA low in the ninth clock) gives status 0x18. NACK gives 0x20.
- R7: Each later byte is sent the same way and gives 0x28 on ACK or 0x30 on NACK.
- R8: Clearing the flag with start set (and stop clear) mid-transfer sends a repeated start and gives status 0x10. The next byte is again treated as the first byte after a start.
- R9: Clearing the flag with stop set sends a stop: SDA rises while SCL is high. The stop bit reads 1 until the stop is complete, then 0. No flag is raised, and status returns to 0xF8. A stop request in idle is dropped with no bus activity.
- R10: If the controller releases SDA for a 1 but samples it low during the SCL high phase of a data bit, it releases both lines, reports 0x38 and sets the flag. Clearing the flag returns it to idle.
- R11: `irq` is flag AND enable. Status reads 0xF8 whenever the flag is clear.
- R12: SDA changes while SCL is high only at a start edge (falling) or a stop edge (rising).
- R13: During a byte, SCL rising edges are 4*QUARTER system clocks apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 8 | Read data (combinational) |
| sda_in | input | 1 | Sampled level of the data wire |
| scl_o | output | 1 | Clock line drive, 1 = released, 0 = pulled low |
| sda_o | output | 1 | Data line drive, 1 = released, 0 = pulled low |
| irq | output | 1 | Service request |

## Verification
Arbitration loss is the hardest case to provoke from the ports. It needs another device to hold SDA low during a high clock phase in which this master has released the line for a 1. The bench models the slave on the wire and pulls SDA low from the falling clock edge before a chosen bit index. That bit is set to 1 in the address byte, so the loss happens mid-byte. The bench then checks that both lines are released and that 0x38 is reported. A second hard case is the repeated start, which the bench reaches by leaving start set when it clears the flag after an acknowledged address byte.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int BYTE_W = 8;
    localparam int BCNT_W = $clog2(BYTE_W);

    // register selects
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;
    localparam logic [1:0] SEL_OWN  = 2'd3;

    // control bit positions
    localparam int CB_EN    = 6;
    localparam int CB_START = 5;
    localparam int CB_STOP  = 4;
    localparam int CB_FLAG  = 3;
    localparam int CB_AA    = 2;

    // event codes
    localparam logic [7:0] CODE_START     = 8'h08;
    localparam logic [7:0] CODE_RSTART    = 8'h10;
    localparam logic [7:0] CODE_ADDR_ACK  = 8'h18;
    localparam logic [7:0] CODE_ADDR_NACK = 8'h20;
    localparam logic [7:0] CODE_DATA_ACK  = 8'h28;
    localparam logic [7:0] CODE_DATA_NACK = 8'h30;
    localparam logic [7:0] CODE_ARB_LOST  = 8'h38;
    localparam logic [7:0] CODE_NONE      = 8'hF8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_S_SETUP,
        ST_S_FALL,
        ST_S_LOW,
        ST_R_REL,
        ST_R_RISE,
        ST_HOLD,
        ST_BIT,
        ST_ACK,
        ST_P_LOW,
        ST_P_RISE,
        ST_P_REL,
        ST_LOST
    } seq_state_t;

endpackage

// File: rtl/i2cm_quarter_tick.sv
module i2cm_quarter_tick #(
    parameter int QUARTER = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (QUARTER > 1) ? $clog2(QUARTER) : 1;
    localparam logic [CW-1:0] LAST = CW'(QUARTER - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/i2cm_sequencer.sv
module i2cm_sequencer
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              flag,
    input  logic              tick,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              sda_in,
    output logic              scl_drv,
    output logic              sda_drv,
    output logic              evt,
    output logic [7:0]        evt_code,
    output logic              stop_done,
    output seq_state_t        state
);
    seq_state_t state_q, state_d;

    logic [1:0]        q_q;
    logic [BYTE_W-1:0] sh_q;
    logic [BCNT_W-1:0] bcnt_q;
    logic              addr_ph_q;
    logic              rs_q;
    logic              acked_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and event generation
    always_comb begin
        state_d   = state_q;
        evt       = 1'b0;
        evt_code  = CODE_NONE;
        stop_done = 1'b0;
        if (!en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (stop_req) begin
                        stop_done = 1'b1;
                    end else if (start_req && !flag) begin
                        state_d = ST_S_SETUP;
                    end
                end
                ST_S_SETUP: if (tick) state_d = ST_S_FALL;
                ST_S_FALL:  if (tick) state_d = ST_S_LOW;
                ST_S_LOW: begin
                    if (tick) begin
                        state_d  = ST_HOLD;
                        evt      = 1'b1;
                        evt_code = rs_q ? CODE_RSTART : CODE_START;
                    end
                end
                ST_R_REL:  if (tick) state_d = ST_R_RISE;
                ST_R_RISE: if (tick) state_d = ST_S_FALL;
                ST_HOLD: begin
                    if (!flag) begin
                        if (stop_req) begin
                            state_d = ST_P_LOW;
                        end else if (start_req) begin
                            state_d = ST_R_REL;
                        end else begin
                            state_d = ST_BIT;
                        end
                    end
                end
                ST_BIT: begin
                    if (tick) begin
                        if (q_q == 2'd2 && sh_q[BYTE_W-1] && !sda_in) begin
                            state_d  = ST_LOST;
                            evt      = 1'b1;
                            evt_code = CODE_ARB_LOST;
                        end else if (q_q == 2'd3 && bcnt_q == '0) begin
                            state_d = ST_ACK;
                        end
                    end
                end
                ST_ACK: begin
                    if (tick && q_q == 2'd3) begin
                        state_d = ST_HOLD;
                        evt     = 1'b1;
                        if (addr_ph_q) begin
                            evt_code = acked_q ? CODE_ADDR_ACK : CODE_ADDR_NACK;
                        end else begin
                            evt_code = acked_q ? CODE_DATA_ACK : CODE_DATA_NACK;
                        end
                    end
                end
                ST_P_LOW:  if (tick) state_d = ST_P_RISE;
                ST_P_RISE: if (tick) state_d = ST_P_REL;
                ST_P_REL: begin
                    if (tick) begin
                        state_d   = ST_IDLE;
                        stop_done = 1'b1;
                    end
                end
                ST_LOST: if (!flag) state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // datapath: quarter phase, shifter, bit count, byte context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q       <= '0;
            sh_q      <= '0;
            bcnt_q    <= '0;
            addr_ph_q <= 1'b0;
            rs_q      <= 1'b0;
            acked_q   <= 1'b0;
        end else begin
            if (state_q == ST_HOLD && state_d == ST_BIT) begin
                sh_q   <= tx_byte;
                bcnt_q <= BCNT_W'(BYTE_W - 1);
                q_q    <= '0;
            end else if (state_q == ST_BIT && tick) begin
                q_q <= q_q + 1'b1;
                if (q_q == 2'd3 && bcnt_q != '0) begin
                    sh_q   <= {sh_q[BYTE_W-2:0], 1'b0};
                    bcnt_q <= bcnt_q - 1'b1;
                end
            end else if (state_q == ST_ACK && tick) begin
                q_q <= q_q + 1'b1;
                if (q_q == 2'd2) begin
                    acked_q <= !sda_in;
                end
            end
            if (state_q == ST_HOLD && state_d == ST_R_REL) begin
                rs_q <= 1'b1;
            end else if (state_q == ST_IDLE) begin
                rs_q <= 1'b0;
            end
            if (evt && state_q == ST_S_LOW) begin
                addr_ph_q <= 1'b1;
            end else if (evt && state_q == ST_ACK) begin
                addr_ph_q <= 1'b0;
            end
        end
    end

    // line drive per state (1 = released)
    always_comb begin
        scl_drv = 1'b1;
        sda_drv = 1'b1;
        unique case (state_q)
            ST_IDLE, ST_S_SETUP, ST_R_RISE, ST_P_REL, ST_LOST: begin
                scl_drv = 1'b1;
                sda_drv = 1'b1;
            end
            ST_S_FALL, ST_P_RISE: begin
                scl_drv = 1'b1;
                sda_drv = 1'b0;
            end
            ST_S_LOW, ST_HOLD, ST_P_LOW: begin
                scl_drv = 1'b0;
                sda_drv = 1'b0;
            end
            ST_R_REL: begin
                scl_drv = 1'b0;
                sda_drv = 1'b1;
            end
            ST_BIT: begin
                scl_drv = (q_q == 2'd1) || (q_q == 2'd2);
                sda_drv = sh_q[BYTE_W-1];
            end
            ST_ACK: begin
                scl_drv = (q_q == 2'd1) || (q_q == 2'd2);
                sda_drv = 1'b1;
            end
            default: begin
                scl_drv = 1'b1;
                sda_drv = 1'b1;
            end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2cm_pkg::*;
#(
    parameter int QUARTER = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_sel,
    output logic [7:0] rd_data,
    input  logic       sda_in,
    output logic       scl_o,
    output logic       sda_o,
    output logic       irq
);
    logic       en_q, start_q, stop_q, flag_q, aa_q;
    logic [7:0] code_q, data_q, own_q;
    logic       tick, evt, stop_done;
    logic [7:0] evt_code;
    seq_state_t fsm_state;

    wire ctrl_wr = wr_en && (wr_sel == SEL_CTRL);

    i2cm_quarter_tick #(.QUARTER(QUARTER)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (en_q),
        .tick  (tick)
    );

    i2cm_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_q),
        .start_req (start_q),
        .stop_req  (stop_q),
        .flag      (flag_q),
        .tick      (tick),
        .tx_byte   (data_q),
        .sda_in    (sda_in),
        .scl_drv   (scl_o),
        .sda_drv   (sda_o),
        .evt       (evt),
        .evt_code  (evt_code),
        .stop_done (stop_done),
        .state     (fsm_state)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            start_q <= 1'b0;
            stop_q  <= 1'b0;
            flag_q  <= 1'b0;
            aa_q    <= 1'b0;
            code_q  <= CODE_NONE;
            data_q  <= '0;
            own_q   <= '0;
        end else begin
            if (ctrl_wr) begin
                en_q    <= wr_data[CB_EN];
                start_q <= wr_data[CB_START];
                aa_q    <= wr_data[CB_AA];
            end
            if (stop_done) begin
                stop_q <= 1'b0;
            end else if (ctrl_wr) begin
                stop_q <= wr_data[CB_STOP];
            end
            if (evt) begin
                flag_q <= 1'b1;
                code_q <= evt_code;
            end else if (ctrl_wr && !wr_data[CB_FLAG]) begin
                flag_q <= 1'b0;
            end
            if (wr_en && wr_sel == SEL_DATA) data_q <= wr_data;
            if (wr_en && wr_sel == SEL_OWN)  own_q  <= wr_data;
        end
    end

    always_comb begin
        unique case (rd_sel)
            SEL_CTRL: rd_data = {1'b0, en_q, start_q, stop_q, flag_q, aa_q, 2'b00};
            SEL_STAT: rd_data = flag_q ? code_q : CODE_NONE;
            SEL_DATA: rd_data = data_q;
            SEL_OWN:  rd_data = own_q;
            default:  rd_data = '0;
        endcase
    end

    assign irq = flag_q && en_q;

endmodule

// File: rtl/i2cm_checks.sv
module i2cm_checks
    import i2cm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       flag,
    input logic       evt,
    input logic [7:0] evt_code,
    input logic       scl,
    input logic       sda,
    input seq_state_t state
);
    // R5
    scl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n || !en)
        (flag && state == ST_HOLD) |=> !scl);

    // R3
    flag_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag);

    // R4
    flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(evt));

    // R10
    arb_release_chk: assert property (@(posedge clk) disable iff (!rst_n || !en)
        (evt && evt_code == CODE_ARB_LOST) |=> (scl && sda));

    // R12
    sda_fall_chk: assert property (@(posedge clk) disable iff (!rst_n || !en)
        (scl && $past(scl) && $fell(sda)) |-> state == ST_S_FALL);

    // R12
    sda_rise_chk: assert property (@(posedge clk) disable iff (!rst_n || !en)
        (scl && $past(scl) && $rose(sda)) |-> state == ST_P_REL);
endmodule

bind i2c_byte_master i2cm_checks u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en_q),
    .flag     (flag_q),
    .evt      (evt),
    .evt_code (evt_code),
    .scl      (scl_o),
    .sda      (sda_o),
    .state    (fsm_state)
);

// File: tb/i2c_byte_master_test.sv
`timescale 1ns/1ps
module i2c_byte_master_test;
    localparam int QUARTER = 5;
    localparam int CYC = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_sel = 2'd0;
    logic [7:0] rd_data;
    logic       scl_o, sda_o, irq;
    wire        sda_bus;

    int nchk = 0;
    int nerr = 0;

    // slave model state
    logic ack_pull = 1'b0, arb_pull = 1'b0;
    logic ack_a = 1'b1, ack_d = 1'b1;
    int   lose_at = -1;
    logic prev_scl = 1'b1, prev_sda = 1'b1;
    int   bitcnt = 0, byte_idx = 0, start_cnt = 0, stop_cnt = 0;
    logic [7:0] shreg = 8'd0, rx_byte = 8'd0;

    assign sda_bus = sda_o & ~(ack_pull | (arb_pull && lose_at >= 0));

    always #(CYC/2) clk = ~clk;

    i2c_byte_master #(.QUARTER(QUARTER)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .sda_in(sda_bus), .scl_o(scl_o), .sda_o(sda_o), .irq(irq)
    );

    // bus-side device model
    always @(scl_o or sda_bus) begin
        if (scl_o && prev_scl && prev_sda && !sda_bus) begin
            start_cnt++; bitcnt = 0; byte_idx = 0; ack_pull = 1'b0;
        end else if (scl_o && prev_scl && !prev_sda && sda_bus) begin
            stop_cnt++;
        end else if (scl_o && !prev_scl) begin
            if (bitcnt < 8) begin
                shreg = {shreg[6:0], sda_bus};
                bitcnt++;
            end
        end else if (!scl_o && prev_scl) begin
            arb_pull = (lose_at >= 0) && (bitcnt == lose_at);
            if (bitcnt == 8) begin
                ack_pull = (byte_idx == 0) ? ack_a : ack_d;
                bitcnt = 9;
            end else if (bitcnt == 9) begin
                ack_pull = 1'b0; rx_byte = shreg; byte_idx++; bitcnt = 0;
            end
        end
        prev_scl = scl_o;
        prev_sda = sda_bus;
    end

    // stimulus table: addr, data, ack_addr, ack_data, expected addr code, expected data code (00 = no data byte)
    localparam logic [33:0] VEC [4] = '{
        {8'hA0, 8'h55, 1'b1, 1'b1, 8'h18, 8'h28},
        {8'hA0, 8'h3C, 1'b1, 1'b0, 8'h18, 8'h30},
        {8'h42, 8'h00, 1'b0, 1'b0, 8'h20, 8'h00},
        {8'hFE, 8'h81, 1'b1, 1'b1, 8'h18, 8'h28}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] v);
        @(negedge clk);
        rd_sel = sel;
        #1 v = rd_data;
    endtask

    task automatic wait_irq(input string tag);
        int n = 0;
        while (!irq && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " irq wait"}, 32'(irq), 32'd1);
    endtask

    task automatic wait_stop(input string tag);
        logic [7:0] v;
        int n = 0;
        rd(2'd0, v);
        while (v[4] && n < 3000) begin
            rd(2'd0, v);
            n++;
        end
        chk({tag, " stop bit clears"}, 32'(v[4]), 32'd0);
    endtask

    task automatic do_xfer(input logic [33:0] v);
        logic [7:0] r;
        int sc0;
        ack_a = v[17]; ack_d = v[16];
        sc0 = stop_cnt;
        wr(2'd0, 8'h60);
        wait_irq("R3");
        rd(2'd1, r); chk("R3 start code", 32'(r), 32'h08);
        wr(2'd2, v[33:26]);
        wr(2'd0, 8'h40);
        wait_irq("R6");
        rd(2'd1, r); chk("R6 addr code", 32'(r), 32'(v[15:8]));
        chk("R6 addr byte on bus", 32'(rx_byte), 32'(v[33:26]));
        if (v[7:0] != 8'h00) begin
            wr(2'd2, v[25:18]);
            wr(2'd0, 8'h40);
            wait_irq("R7");
            rd(2'd1, r); chk("R7 data code", 32'(r), 32'(v[7:0]));
            chk("R7 data byte on bus", 32'(rx_byte), 32'(v[25:18]));
        end
        wr(2'd0, 8'h50);
        rd(2'd0, r); chk("R9 stop pending reads 1", 32'(r[4]), 32'd1);
        wait_stop("R9");
        rd(2'd1, r); chk("R9 status after stop", 32'(r), 32'hF8);
        chk("R9 stop on bus", 32'(stop_cnt - sc0), 32'd1);
        chk("R11 irq low after stop", 32'(irq), 32'd0);
    endtask

    initial begin
        #(CYC * 150000);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [7:0] r;
        int sc0, st0, highs;
        longint t1, t2;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd1, r); chk("R1 status", 32'(r), 32'hF8);
        rd(2'd0, r); chk("R1 control", 32'(r), 32'h00);
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 scl released", 32'(scl_o), 32'd1);
        chk("R1 sda released", 32'(sda_o), 32'd1);

        // R2 register map
        wr(2'd3, 8'h5A); rd(2'd3, r); chk("R2 own address", 32'(r), 32'h5A);
        wr(2'd2, 8'h3C); rd(2'd2, r); chk("R2 data register", 32'(r), 32'h3C);
        wr(2'd0, 8'h44); rd(2'd0, r); chk("R2 enable+aa", 32'(r), 32'h44);
        wr(2'd0, 8'h87); rd(2'd0, r); chk("R2 unused bits read 0", 32'(r), 32'h04);

        // R4 flag cannot be set by software
        wr(2'd0, 8'h48); rd(2'd0, r); chk("R4 flag write 1 ignored", 32'(r), 32'h40);
        rd(2'd1, r); chk("R4 status stays idle", 32'(r), 32'hF8);
        chk("R4 irq stays low", 32'(irq), 32'd0);

        // R9 stop in idle is dropped
        sc0 = stop_cnt;
        wr(2'd0, 8'h50);
        repeat (3) @(negedge clk);
        rd(2'd0, r); chk("R9 idle stop dropped", 32'(r), 32'h40);
        chk("R9 idle stop no bus edge", 32'(stop_cnt - sc0), 32'd0);

        // table-driven transfers
        for (int i = 0; i < 4; i++) begin
            do_xfer(VEC[i]);
        end

        // R5, R13, R8 repeated start
        ack_a = 1'b1; ack_d = 1'b1;
        wr(2'd0, 8'h60);
        wait_irq("R5");
        highs = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (scl_o) highs++;
        end
        chk("R5 scl held low while flag set", 32'(highs), 32'd0);
        wr(2'd2, 8'hA0); wr(2'd0, 8'h40);
        wait_irq("R6");
        rd(2'd1, r); chk("R6 addr ack", 32'(r), 32'h18);
        wr(2'd2, 8'h11); wr(2'd0, 8'h40);
        @(posedge scl_o); t1 = $time;
        @(posedge scl_o); t2 = $time;
        chk("R13 scl period", 32'(t2 - t1), 32'(4 * QUARTER * CYC));
        wait_irq("R7");
        rd(2'd1, r); chk("R7 data ack", 32'(r), 32'h28);
        st0 = start_cnt;
        wr(2'd0, 8'h60);
        wait_irq("R8");
        rd(2'd1, r); chk("R8 repeated start code", 32'(r), 32'h10);
        chk("R8 start edge on bus", 32'(start_cnt - st0), 32'd1);
        wr(2'd2, 8'hA1); wr(2'd0, 8'h40);
        wait_irq("R8");
        rd(2'd1, r); chk("R8 byte after rstart is address", 32'(r), 32'h18);
        wr(2'd0, 8'h50);
        wait_stop("R9");

        // R10 arbitration loss
        lose_at = 2;
        wr(2'd0, 8'h60);
        wait_irq("R10");
        wr(2'd2, 8'hE0); wr(2'd0, 8'h40);
        wait_irq("R10");
        rd(2'd1, r); chk("R10 arbitration code", 32'(r), 32'h38);
        chk("R10 scl released", 32'(scl_o), 32'd1);
        chk("R10 sda released", 32'(sda_o), 32'd1);
        lose_at = -1;
        wr(2'd0, 8'h40);
        repeat (20) @(negedge clk);
        rd(2'd1, r); chk("R10 idle after clear", 32'(r), 32'hF8);
        chk("R10 scl stays released", 32'(scl_o), 32'd1);
        chk("R11 irq low with flag clear", 32'(irq), 32'd0);

        // R11 irq gated by enable, R4 write 1 keeps flag
        wr(2'd0, 8'h60);
        wait_irq("R11");
        wr(2'd0, 8'h08);
        chk("R11 irq low when disabled", 32'(irq), 32'd0);
        rd(2'd0, r); chk("R4 flag kept by write 1", 32'(r), 32'h08);
        wr(2'd0, 8'h48);
        chk("R11 irq back with enable", 32'(irq), 32'd1);
        rd(2'd1, r); chk("R11 status while flagged", 32'(r), 32'h08);
        wr(2'd0, 8'h40);
        rd(2'd1, r); chk("R11 status after clear", 32'(r), 32'hF8);
        chk("R11 irq after clear", 32'(irq), 32'd0);

        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule